// File: doc/BRIEF.md
# Packet Width Down-Converter

This block takes framed packets arriving on a wide valid/ready stream and re-encodes them for a narrower stream. An example is 256-bit input words re-encoded as 64-bit output words. Each wide input word is cut into `IN_W/OUT_W` lanes. Lane 0 holds the least significant bits and is handled first. Each lane is either emitted as one output word or skipped.

The first lane of each packet carries a 64-bit header. The block rewrites the header's metadata-count and length fields for the narrower word size. Metadata lanes are kept only up to the 5-bit count limit. Payload lanes that lie entirely in the padding of the last input word are dropped. Management packets get different handling: each input payload word keeps only its low lane, and that lane carries a width tag.

A per-packet side-band value (`in_user`) travels with every output word. When both widths are equal, the block is a set of wires.

Back-pressure rules:
- An input word is accepted only on the cycle its last lane is emitted or skipped, so it is held for one or more cycles.
- `out_valid` never depends on `out_ready`.
- While `out_ready` is low, the presented output word stays unchanged.

Top module: `pkt_width_down`

## Requirements
- R1: After reset, `out_valid` is low and no output word is produced until an input word is presented.
- R2: The header occupies bits 63:0 of the first word of a packet, with these fields: channel 63:58, end flags 57:56, type 55:53, metadata count 52:48, sequence 47:32, byte length 31:16, destination 15:0. Every header field other than count and length is copied unchanged. The header is always the first output word of a packet.
- R3: The output metadata count is min(input count × IN_W/OUT_W, 31). Only that many metadata lanes are emitted, in lane order, and the rest are dropped.
- R4: Let P be the input length minus IN_W/8 × (1 + input metadata count). For non-management packets, exactly ceil(P / (OUT_W/8)) payload lanes are emitted, and later lanes are dropped.
- R5: When OUT_W is 64 and the type is 7 (data with timestamp), lane 1 of the header word is emitted as a separate timestamp word right after the header. For any other type or width, no such word is emitted.
- R6: The output length is OUT_W/8 × (1 + timestamp word + output metadata count) plus either P, or, for management packets, the number of input payload words × OUT_W/8.
- R7: For type 0 (management), each input payload word yields one output word made of its lowest lane. The number of input payload words is ceil(P / (IN_W/8)), so a length that includes or excludes the last word's padding gives identical output.
- R8: In the first management payload output word, bits 47:45 hold log2(OUT_W/64): 0 for 64, 1 for 128, 2 for 256, 3 for 512.
- R9: `out_user` equals the `in_user` of the packet on every output word of that packet.
- R10: `out_last` is high on exactly the final emitted word of each packet. This happens no later than the acceptance of the input word that carries `in_last`.
- R11: `in_ready` is high only while the last lane of the current word is being emitted or skipped, and never while an emitted lane is stalled. A stalled output word holds its data, last and user values.
- R12: With IN_W equal to OUT_W, every output equals the matching input unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | IN_W | Wide input word |
| in_user | input | USER_W | Per-packet side-band value |
| in_last | input | 1 | Last input word of a packet |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted |
| out_data | output | OUT_W | Narrow output word |
| out_user | output | USER_W | Side-band value of the current packet |
| out_last | output | 1 | Last output word of a packet |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Output word taken |

## Verification
The assertions assume an upstream that holds `in_data`, `in_user` and `in_last` steady while a word waits for `in_ready`. They also assume `in_user` is constant across a packet, and that header lengths and `in_last` agree with the number of words sent. The stimulus builds each packet from its header fields, so the length always matches the word count. It raises `in_valid` for a new word only when no word is pending, and then holds that word until its handshake. Only `out_ready` and the gaps between words are randomised, each from a fixed-seed shift register.

// File: rtl/pkt_dn_pkg.sv
package pkt_dn_pkg;

  localparam int HDR_W     = 64;
  localparam int MD_MAX    = 31;
  localparam int CNT_W     = 17;
  localparam int WTAG_LO   = 45;
  localparam int WTAG_HI   = 47;

  typedef enum logic [2:0] {
    PT_MGMT    = 3'd0,
    PT_STAT    = 3'd1,
    PT_CMD     = 3'd2,
    PT_CTRL    = 3'd4,
    PT_DATA    = 3'd6,
    PT_DATA_TS = 3'd7
  } pkt_type_e;

  typedef enum logic [1:0] {
    PH_HDR,
    PH_MD,
    PH_PL
  } phase_e;

  typedef struct packed {
    logic [5:0]  chan;
    logic        eob;
    logic        eov;
    logic [2:0]  ptype;
    logic [4:0]  n_md;
    logic [15:0] seq;
    logic [15:0] len;
    logic [15:0] dst;
  } hdr_t;

  function automatic logic [2:0] width_tag(input int w);
    return 3'($clog2(w / HDR_W));
  endfunction

endpackage

// File: rtl/pkt_dn_hdr_calc.sv
module pkt_dn_hdr_calc
  import pkt_dn_pkg::*;
#(
  parameter int IN_W  = 256,
  parameter int OUT_W = 64
) (
  input  hdr_t             hdr_in,
  output hdr_t             hdr_out,
  output logic             ts_sep,
  output logic             mgmt,
  output logic [4:0]       md_out,
  output logic [CNT_W-1:0] pay_out,
  output logic [CNT_W-1:0] total
);

  localparam int RATIO = IN_W / OUT_W;
  localparam int IN_B  = IN_W / 8;
  localparam int OUT_B = OUT_W / 8;

  int md_scaled;
  int md_cnt;
  int ts_i;
  int pay_b;
  int in_words;
  int nr_words;
  int pay_cnt;
  int len_o;

  always_comb begin
    md_scaled = int'(hdr_in.n_md) * RATIO;
    md_cnt    = (md_scaled > MD_MAX) ? MD_MAX : md_scaled;
    mgmt      = (hdr_in.ptype == PT_MGMT);
    ts_sep    = (OUT_W == HDR_W) && (hdr_in.ptype == PT_DATA_TS);
    ts_i      = ts_sep ? 1 : 0;
    pay_b     = int'(hdr_in.len) - IN_B * (1 + int'(hdr_in.n_md));
    in_words  = (pay_b + IN_B - 1) / IN_B;
    nr_words  = (pay_b + OUT_B - 1) / OUT_B;
    pay_cnt   = mgmt ? in_words : nr_words;
    len_o     = OUT_B * (1 + ts_i + md_cnt) + (mgmt ? in_words * OUT_B : pay_b);
    hdr_out       = hdr_in;
    hdr_out.n_md  = 5'(md_cnt);
    hdr_out.len   = 16'(len_o);
    md_out    = 5'(md_cnt);
    pay_out   = CNT_W'(pay_cnt);
    total     = CNT_W'(1 + ts_i + md_cnt + pay_cnt);
  end

endmodule

// File: rtl/pkt_dn_seq.sv
module pkt_dn_seq
  import pkt_dn_pkg::*;
#(
  parameter int RATIO = 4,
  parameter int SL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             out_ready,
  input  logic             new_ts_sep,
  input  logic             new_mgmt,
  input  logic [4:0]       new_md_out,
  input  logic [4:0]       new_md_in,
  input  logic [CNT_W-1:0] new_pay_out,
  input  logic [CNT_W-1:0] new_total,
  output logic [SL_W-1:0]  slice,
  output logic             hdr_slot,
  output logic             pl_first,
  output logic             emit,
  output logic             last_word,
  output logic             adv,
  output logic             take_in
);

  phase_e           phase;
  logic             ts_q;
  logic             mgmt_q;
  logic [4:0]       md_q;
  logic [4:0]       md_left;
  logic [CNT_W-1:0] pay_q;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] ocnt;
  logic [CNT_W-1:0] pos;
  logic             last_slice;

  always_comb begin
    last_slice = (slice == SL_W'(RATIO - 1));
    hdr_slot   = (phase == PH_HDR) && (slice == '0);
    pl_first   = (phase == PH_PL) && mgmt_q && (pos == '0);
    case (phase)
      PH_HDR:  emit = hdr_slot || ((slice == SL_W'(1)) && ts_q);
      PH_MD:   emit = (pos < CNT_W'(md_q));
      default: emit = mgmt_q ? ((slice == '0) && ((pos >> SL_W) < pay_q))
                             : (pos < pay_q);
    endcase
    last_word = hdr_slot ? (new_total == CNT_W'(1))
                         : (ocnt == total_q - CNT_W'(1));
    adv       = in_valid && (!emit || out_ready);
    take_in   = last_slice && (!emit || out_ready);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slice   <= '0;
      phase   <= PH_HDR;
      ts_q    <= 1'b0;
      mgmt_q  <= 1'b0;
      md_q    <= '0;
      md_left <= '0;
      pay_q   <= '0;
      total_q <= '0;
      ocnt    <= '0;
      pos     <= '0;
    end else if (adv) begin
      slice <= last_slice ? '0 : slice + SL_W'(1);
      if (emit) ocnt <= hdr_slot ? CNT_W'(1) : ocnt + CNT_W'(1);
      if (hdr_slot) begin
        ts_q    <= new_ts_sep;
        mgmt_q  <= new_mgmt;
        md_q    <= new_md_out;
        md_left <= new_md_in;
        pay_q   <= new_pay_out;
        total_q <= new_total;
      end
      if (last_slice) begin
        pos <= '0;
        if (in_last) begin
          phase <= PH_HDR;
        end else begin
          case (phase)
            PH_HDR: phase <= (md_left == 5'd0) ? PH_PL : PH_MD;
            PH_MD: begin
              md_left <= md_left - 5'd1;
              if (md_left == 5'd1) phase <= PH_PL;
              else pos <= pos + CNT_W'(1);
            end
            default: pos <= pos + CNT_W'(1);
          endcase
        end
      end else if (phase != PH_HDR) begin
        pos <= pos + CNT_W'(1);
      end
    end
  end

  // R11: the lane counter never leaves the word
  always_comb begin
    if (!rst) assert_lane_range_R11: assert (32'(slice) < RATIO);
  end

endmodule

// File: rtl/pkt_dn_mux.sv
module pkt_dn_mux
  import pkt_dn_pkg::*;
#(
  parameter int IN_W  = 256,
  parameter int OUT_W = 64,
  parameter int RATIO = 4,
  parameter int SL_W  = 2
) (
  input  logic [IN_W-1:0]  in_data,
  input  logic [SL_W-1:0]  slice,
  input  logic             hdr_slot,
  input  logic             pl_first,
  input  hdr_t             hdr_new,
  output logic [OUT_W-1:0] out_data
);

  logic [OUT_W-1:0] lanes [RATIO];

  for (genvar g = 0; g < RATIO; g++) begin : g_lane
    assign lanes[g] = in_data[g*OUT_W +: OUT_W];
  end

  always_comb begin
    out_data = lanes[slice];
    if (hdr_slot) out_data[HDR_W-1:0] = hdr_new;
    else if (pl_first) out_data[WTAG_HI:WTAG_LO] = width_tag(OUT_W);
  end

endmodule

// File: rtl/pkt_width_down.sv
module pkt_width_down
  import pkt_dn_pkg::*;
#(
  parameter int IN_W   = 256,
  parameter int OUT_W  = 64,
  parameter int USER_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   in_data,
  input  logic [USER_W-1:0] in_user,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic [USER_W-1:0] out_user,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready
);

  localparam int RATIO = IN_W / OUT_W;
  localparam int SL_W  = (RATIO > 1) ? $clog2(RATIO) : 1;

  if (IN_W == OUT_W) begin : g_pass
    assign out_data  = in_data;
    assign out_user  = in_user;
    assign out_last  = in_last;
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
  end else begin : g_conv
    hdr_t             hdr_new;
    logic             ts_sep;
    logic             mgmt;
    logic [4:0]       md_out;
    logic [CNT_W-1:0] pay_out;
    logic [CNT_W-1:0] total;
    logic [SL_W-1:0]  slice;
    logic             hdr_slot;
    logic             pl_first;
    logic             emit;
    logic             last_word;
    logic             adv;
    logic             take_in;
    hdr_t             hdr_in;

    assign hdr_in = hdr_t'(in_data[HDR_W-1:0]);

    pkt_dn_hdr_calc #(.IN_W(IN_W), .OUT_W(OUT_W)) hdr_calc_i (
      .hdr_in  (hdr_in),
      .hdr_out (hdr_new),
      .ts_sep  (ts_sep),
      .mgmt    (mgmt),
      .md_out  (md_out),
      .pay_out (pay_out),
      .total   (total)
    );

    pkt_dn_seq #(.RATIO(RATIO), .SL_W(SL_W)) seq_i (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .in_last     (in_last),
      .out_ready   (out_ready),
      .new_ts_sep  (ts_sep),
      .new_mgmt    (mgmt),
      .new_md_out  (md_out),
      .new_md_in   (hdr_in.n_md),
      .new_pay_out (pay_out),
      .new_total   (total),
      .slice       (slice),
      .hdr_slot    (hdr_slot),
      .pl_first    (pl_first),
      .emit        (emit),
      .last_word   (last_word),
      .adv         (adv),
      .take_in     (take_in)
    );

    pkt_dn_mux #(.IN_W(IN_W), .OUT_W(OUT_W), .RATIO(RATIO), .SL_W(SL_W)) mux_i (
      .in_data  (in_data),
      .slice    (slice),
      .hdr_slot (hdr_slot),
      .pl_first (pl_first),
      .hdr_new  (hdr_new),
      .out_data (out_data)
    );

    assign out_valid = in_valid && emit;
    assign out_last  = last_word;
    assign out_user  = in_user;
    assign in_ready  = take_in;

    // Port-level observers for the properties below
    logic              mid_q;
    logic              seen_last_q;
    logic              await_hdr_q;
    logic [USER_W-1:0] user_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        mid_q       <= 1'b0;
        seen_last_q <= 1'b0;
        await_hdr_q <= 1'b1;
        user_q      <= '0;
      end else begin
        if (out_valid && out_ready) begin
          mid_q       <= !out_last;
          user_q      <= out_user;
          await_hdr_q <= out_last;
        end
        if (in_valid && in_ready && in_last) seen_last_q <= 1'b0;
        else if (out_valid && out_ready && out_last) seen_last_q <= 1'b1;
      end
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data)
                                 && $stable(out_last) && $stable(out_user));

    assert_no_early_take_R11: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && out_valid |-> out_ready);

    assert_user_steady_R9: assert property (@(posedge clk) disable iff (rst)
      out_valid && mid_q |-> out_user == user_q);

    assert_last_in_time_R10: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && in_last |->
        seen_last_q || (out_valid && out_ready && out_last));

    assert_header_first_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid && await_hdr_q |-> hdr_slot);
  end

endmodule

// File: tb/pkt_width_down_tb_top.sv
module pkt_width_down_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W   = 256;
  localparam int OUT_W  = 64;
  localparam int USER_W = 4;
  localparam int RATIO  = IN_W / OUT_W;
  localparam int IN_B   = IN_W / 8;
  localparam int OUT_B  = OUT_W / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [IN_W-1:0]   in_data  = '0;
  logic [USER_W-1:0] in_user  = '0;
  logic              in_last  = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [OUT_W-1:0]  out_data;
  logic [USER_W-1:0] out_user;
  logic              out_last;
  logic              out_valid;
  logic              out_ready = 1'b0;

  pkt_width_down #(.IN_W(IN_W), .OUT_W(OUT_W), .USER_W(USER_W)) dut_i (
    .clk(clk), .rst(rst),
    .in_data(in_data), .in_user(in_user), .in_last(in_last),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_user(out_user), .out_last(out_last),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  logic [63:0] eq_in_data = '0;
  logic [3:0]  eq_in_user = '0;
  logic        eq_in_last = 1'b0;
  logic        eq_in_valid = 1'b0;
  logic        eq_in_ready;
  logic [63:0] eq_out_data;
  logic [3:0]  eq_out_user;
  logic        eq_out_last;
  logic        eq_out_valid;
  logic        eq_out_ready = 1'b0;

  pkt_width_down #(.IN_W(64), .OUT_W(64), .USER_W(4)) dut_eq (
    .clk(clk), .rst(rst),
    .in_data(eq_in_data), .in_user(eq_in_user), .in_last(eq_in_last),
    .in_valid(eq_in_valid), .in_ready(eq_in_ready),
    .out_data(eq_out_data), .out_user(eq_out_user), .out_last(eq_out_last),
    .out_valid(eq_out_valid), .out_ready(eq_out_ready)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [IN_W-1:0]   iw [0:15];
  logic [63:0]       ew [0:63];
  logic [63:0]       gw [0:63];
  logic              gl [0:63];
  logic [USER_W-1:0] gu [0:63];
  int n_in, n_exp, n_got;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] lane_val(input logic [63:0] tag, input int k, input int s);
    return tag | 64'(k << 8) | 64'(s);
  endfunction

  // Builds one packet and its expected narrow words, runs it, compares.
  task automatic run_pkt(input string req, input logic [2:0] ptype, input int n_md,
                         input int pay_bytes, input bit pad_len,
                         input logic [USER_W-1:0] user, input bit stall);
    int n_pw, len_in, md_o, ts, mg, pout, len_o, wi, cyc;
    bit presenting, done_out;
    logic [63:0] hdr, ts_v, h_o, v;
    n_pw   = (pay_bytes + IN_B - 1) / IN_B;
    len_in = IN_B * (1 + n_md) + (pad_len ? n_pw * IN_B : pay_bytes);
    hdr    = {6'h2A, 1'b1, 1'b0, ptype, 5'(n_md), 16'h1234, 16'(len_in), 16'hBEEF};
    ts_v   = 64'hFACE_0000_1111_2222;
    iw[0]  = {64'hDEAD_0000_0000_0003, 64'hDEAD_0000_0000_0002, ts_v, hdr};
    for (int k = 0; k < n_md; k++)
      for (int s = 0; s < RATIO; s++)
        iw[1+k][s*OUT_W +: OUT_W] = lane_val(64'hA000_0000_0000_0000, k, s);
    for (int k = 0; k < n_pw; k++)
      for (int s = 0; s < RATIO; s++)
        iw[1+n_md+k][s*OUT_W +: OUT_W] = lane_val(64'hB000_F000_0000_0000, k, s);
    n_in = 1 + n_md + n_pw;

    md_o  = (n_md * RATIO > 31) ? 31 : n_md * RATIO;
    ts    = (ptype == 3'd7) ? 1 : 0;
    mg    = (ptype == 3'd0) ? 1 : 0;
    pout  = mg ? n_pw : (pay_bytes + OUT_B - 1) / OUT_B;
    len_o = OUT_B * (1 + ts + md_o) + (mg ? n_pw * OUT_B : pay_bytes);
    h_o   = hdr;
    h_o[52:48] = 5'(md_o);
    h_o[31:16] = 16'(len_o);
    n_exp = 0;
    ew[n_exp++] = h_o;
    if (ts == 1) ew[n_exp++] = ts_v;
    for (int i = 0; i < md_o; i++)
      ew[n_exp++] = lane_val(64'hA000_0000_0000_0000, i / RATIO, i % RATIO);
    for (int i = 0; i < pout; i++) begin
      if (mg == 1) begin
        v = lane_val(64'hB000_F000_0000_0000, i, 0);
        if (i == 0) v[47:45] = 3'd0;
      end else begin
        v = lane_val(64'hB000_F000_0000_0000, i / RATIO, i % RATIO);
      end
      ew[n_exp++] = v;
    end

    n_got = 0; wi = 0; cyc = 0; presenting = 0; done_out = 0;
    while ((wi < n_in || !done_out) && cyc < 3000) begin
      @(negedge clk);
      if (!presenting && wi < n_in) presenting = !(stall && lfsr[0]);
      in_valid  = presenting;
      in_data   = presenting ? iw[wi] : '0;
      in_last   = presenting && (wi == n_in - 1);
      in_user   = user;
      out_ready = !(stall && lfsr[3]);
      #1;
      if (out_valid && out_ready) begin
        if (n_got < 64) begin
          gw[n_got] = out_data; gl[n_got] = out_last; gu[n_got] = out_user;
        end
        n_got++;
        if (out_last) done_out = 1;
      end
      if (in_valid && in_ready) begin wi++; presenting = 0; end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;

    chk(n_got == n_exp, req, "word count", 64'(n_got), 64'(n_exp));
    for (int i = 0; i < n_exp && i < n_got && i < 64; i++) begin
      chk(gw[i] == ew[i], (i == 0) ? "R2 R6" : req, $sformatf("word %0d", i), gw[i], ew[i]);
      chk(gl[i] == (i == n_exp - 1), "R10", $sformatf("last flag %0d", i),
          64'(gl[i]), 64'(i == n_exp - 1));
      chk(gu[i] == user, "R9", $sformatf("user %0d", i), 64'(gu[i]), 64'(user));
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b0, "R11", "in_ready on lane 0", 64'(in_ready), 64'd0);
  endtask

  task automatic t_trim;        run_pkt("R4", 3'd6, 0, 20, 0, 4'h1, 0); endtask
  task automatic t_ts_meta;     run_pkt("R5", 3'd7, 2, 64, 0, 4'h2, 0); endtask
  task automatic t_clamp;       run_pkt("R3", 3'd6, 9, 8, 0, 4'h3, 0); endtask
  task automatic t_mgmt_short;  run_pkt("R7 R8", 3'd0, 0, 80, 0, 4'h4, 0); endtask
  task automatic t_mgmt_padded; run_pkt("R7 R8", 3'd0, 0, 80, 1, 4'h5, 0); endtask
  task automatic t_stall;       run_pkt("R11", 3'd4, 1, 96, 0, 4'h9, 1); endtask

  task automatic t_back_to_back;
    run_pkt("R9", 3'd6, 1, 40, 0, 4'hA, 1);
    run_pkt("R9", 3'd7, 0, 7, 0, 4'hB, 1);
    run_pkt("R9", 3'd0, 1, 48, 1, 4'hC, 1);
  endtask

  task automatic t_equal;
    @(negedge clk);
    eq_in_data = 64'h0123_4567_89AB_CDEF; eq_in_user = 4'h6;
    eq_in_last = 1'b1; eq_in_valid = 1'b1; eq_out_ready = 1'b1;
    #1;
    chk(eq_out_data == eq_in_data, "R12", "data", eq_out_data, eq_in_data);
    chk(eq_out_valid && eq_out_last && eq_in_ready && eq_out_user == 4'h6,
        "R12", "controls", {eq_out_valid, eq_out_last, eq_in_ready, eq_out_user}, 64'h7_6);
    eq_in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_trim();
    t_ts_meta();
    t_clamp();
    t_mgmt_short();
    t_mgmt_padded();
    t_stall();
    t_back_to_back();
    t_equal();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule